// File: doc/BRIEF.md
# Dual-Channel DAC Code Loader with Trigger Selection and DMA Pacing

This block is the digital side of a two-channel 12-bit digital-to-analog converter. Software or a DMA engine writes sample values into a per-channel holding register over a small word-addressed register bus. Three data layouts are accepted: 12 bits right-justified, 12 bits left-justified, and 8 bits. A combined write can also load both channels in one access. The block moves each holding value into the channel's 12-bit output code. It does this either on the clock after the write, or on a trigger event picked from an external line, a set of timer event inputs, or a software strobe.

For hardware trigger events, each channel can request a new sample from a DMA engine. A small two-state machine per channel tracks the request. If a second hardware trigger arrives before the DMA engine has acknowledged the first request, the block records an underrun. That flag is sticky and cleared by writing 1 to it, and it can drive the interrupt line.

Per-channel request machine (`dreq_state_e`):
- **DQ_IDLE**: no request is outstanding. It moves to DQ_PEND when a hardware trigger fires while DMA is enabled for that channel.
- **DQ_PEND**: the request output is high. It returns to DQ_IDLE on an acknowledge in a cycle with no new hardware trigger. If a hardware trigger fires while in this state, the machine reports an underrun and stays in DQ_PEND.

Register map (word address on `bus_addr`):
- 0: control
- 1: software strobe
- 2, 3, 4: channel 0 data in the 12-bit right, 12-bit left and 8-bit layouts
- 5, 6, 7: channel 1 data in the same three layouts
- 8, 9, 10: combined data in the same three layouts
- 11: output readback
- 12: underrun status

Top module: `dac_front_ctrl`

## Requirements
- R1: After reset, both output codes are 0, no DMA request is raised, `irq` is low, and the control, strobe, status and readback registers read 0.
- R2: Single-channel data writes are converted as follows. The 12-bit right layout takes `bus_wdata[11:0]`. The 12-bit left layout takes `bus_wdata[15:4]`. The 8-bit layout takes `bus_wdata[7:0]` and places it as code bits [11:4], with bits [3:0] set to zero.
- R3: A combined write loads both holding registers in the same cycle. In the two 12-bit layouts, channel 0 comes from bits [15:0] and channel 1 from bits [31:16], each converted as in R2. In the 8-bit layout, channel 0 comes from bits [7:0] and channel 1 from bits [15:8].
- R4: When a channel is enabled and its trigger enable is 0, its output code equals the holding value one clock after the holding register was written.
- R5: When triggering is on, a rising edge on the selected hardware source reaches the output code on the second clock edge after the source is seen high. A source held high does not fire again, and sources that are not selected have no effect. The selector values are: 0 = the external line, 1 to NUM_TMR = timer input 0 to NUM_TMR-1, 7 = software.
- R6: Software strobe bit c (address 1) triggers channel c on the next clock, if that channel selects source 7. Writing 3 triggers both channels on the same edge. The strobe bits read back as 0 one clock after they are set.
- R7: A DMA request (a level on `dma_req[c]`) starts only from a hardware trigger while DMA is enabled for that channel, never from the software strobe. It stays high until `dma_ack[c]` is seen.
- R8: A hardware trigger on a channel whose request is still pending sets status bit c at address 12.
- R9: Writing 1 to a status bit clears it. `irq` is high exactly when some status bit is set and that channel's interrupt enable is 1.
- R10: A control write leaves a channel's trigger selector unchanged while that channel is enabled. The other fields still update. Control bits per channel c, starting at bit 8c: [0] enable, [1] trigger enable, [4:2] selector, [5] DMA enable, [6] underrun interrupt enable.
- R11: Address 11 reads channel 0's code in bits [11:0] and channel 1's code in bits [27:16].
- R12: A disabled channel's output code does not change, whatever is written or triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_trig | input | 1 | External trigger line |
| tmr_trig | input | NUM_TMR | Timer event inputs |
| dma_ack | input | 2 | DMA acknowledge per channel |
| dac_code | output | 24 | Output codes; channel 0 in [11:0], channel 1 in [23:12] |
| dma_req | output | 2 | DMA request per channel |
| irq | output | 1 | Underrun interrupt |

## Verification
The data path is exercised with a table of writes that covers every layout on each channel and all three combined layouts. The words used carry ones in bits that each layout must discard, so a wrong slice or a wrong shift shows up as a wrong code. The trigger path is tested with a source that is not selected, a single edge, a level held high and a second edge. These separate edge detection from level sensing, and they show the two-edge latency against a one-edge latency. The request machine is driven into a pending state and then triggered again before the acknowledge, which distinguishes underrun detection from a request that is simply re-raised. A software strobe on both channels checks that it loads both codes and raises no DMA request.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    localparam int CODE_W = 12;
    localparam int NUM_CH = 2;
    localparam logic [2:0] TSEL_SW = 3'd7;

    typedef enum logic [3:0] {
        A_CTRL   = 4'd0,
        A_SWTRIG = 4'd1,
        A_C0_R12 = 4'd2,
        A_C0_L12 = 4'd3,
        A_C0_R8  = 4'd4,
        A_C1_R12 = 4'd5,
        A_C1_L12 = 4'd6,
        A_C1_R8  = 4'd7,
        A_DU_R12 = 4'd8,
        A_DU_L12 = 4'd9,
        A_DU_R8  = 4'd10,
        A_OUT    = 4'd11,
        A_STAT   = 4'd12
    } reg_addr_e;

    typedef enum logic [1:0] {FMT_R12, FMT_L12, FMT_R8} fmt_e;

    typedef enum logic {DQ_IDLE, DQ_PEND} dreq_state_e;

    typedef struct packed {
        logic       udr_ie;
        logic       dma_en;
        logic [2:0] tsel;
        logic       trig_en;
        logic       en;
    } ch_cfg_t;

    function automatic logic [CODE_W-1:0] fmt_align(fmt_e f, logic [15:0] w);
        case (f)
            FMT_L12: return w[15:4];
            FMT_R8:  return {w[7:0], 4'b0000};
            default: return w[11:0];
        endcase
    endfunction
endpackage

// File: rtl/dac_fe_trig.sv
module dac_fe_trig
    import dac_fe_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_in,
    input  logic [NUM_TMR-1:0] tmr_in,
    input  logic [2:0]         tsel,
    input  logic               sw_bit,
    output logic               fire,
    output logic               hw_fire
);
    localparam int NSRC = NUM_TMR + 1;

    logic [NSRC-1:0] src, prev_q, rise;
    logic            sel_rise, hw_q;

    assign src  = {tmr_in, ext_in};
    assign rise = src & ~prev_q;

    always_comb begin
        sel_rise = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (int'(tsel) == i) sel_rise = rise[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            hw_q   <= 1'b0;
        end else begin
            prev_q <= src;
            hw_q   <= sel_rise;
        end
    end

    assign hw_fire = hw_q & (tsel != TSEL_SW);
    assign fire    = (tsel == TSEL_SW) ? sw_bit : hw_q;
endmodule

// File: rtl/dac_fe_dreq.sv
module dac_fe_dreq
    import dac_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_go,
    input  logic dma_en,
    input  logic ack,
    output logic req,
    output logic underrun
);
    dreq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DQ_IDLE: if (hw_go && dma_en) state_d = DQ_PEND;
            DQ_PEND: if (!hw_go && ack)   state_d = DQ_IDLE;
            default: state_d = DQ_IDLE;
        endcase
    end

    always_comb begin
        req      = (state_q == DQ_PEND);
        underrun = (state_q == DQ_PEND) && hw_go;
    end

    // R7: a pending request stays up until it is acknowledged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req);
    // R7: a request only starts from a hardware trigger with DMA enabled
    p_req_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(hw_go && dma_en));
endmodule

// File: rtl/dac_fe_chan.sv
module dac_fe_chan
    import dac_fe_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               trig_en,
    input  logic [2:0]         tsel,
    input  logic               dma_en,
    input  logic               ext_in,
    input  logic [NUM_TMR-1:0] tmr_in,
    input  logic               sw_bit,
    input  logic               hold_we,
    input  logic [CODE_W-1:0]  hold_wv,
    input  logic               dma_ack,
    output logic [CODE_W-1:0]  code,
    output logic               dma_req,
    output logic               underrun,
    output logic               hw_go
);
    logic [CODE_W-1:0] hold_q;
    logic              fire, hw_fire, go, load;

    dac_fe_trig #(.NUM_TMR(NUM_TMR)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_in),
        .tmr_in (tmr_in),
        .tsel   (tsel),
        .sw_bit (sw_bit),
        .fire   (fire),
        .hw_fire(hw_fire)
    );

    assign go    = en & trig_en & fire;
    assign hw_go = en & trig_en & hw_fire;
    assign load  = en & (~trig_en | go);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            code   <= '0;
        end else begin
            if (hold_we) hold_q <= hold_wv;
            if (load)    code   <= hold_q;
        end
    end

    dac_fe_dreq u_dreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_go   (hw_go),
        .dma_en  (dma_en),
        .ack     (dma_ack),
        .req     (dma_req),
        .underrun(underrun)
    );

    // R12: a disabled channel keeps its code
    p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(code));
    // R4: untriggered channel follows its holding value one clock later
    p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !trig_en |=> code == $past(hold_q));
endmodule

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
    import dac_fe_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [3:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       ext_trig,
    input  logic [NUM_TMR-1:0]         tmr_trig,
    input  logic [NUM_CH-1:0]          dma_ack,
    output logic [NUM_CH*CODE_W-1:0]   dac_code,
    output logic [NUM_CH-1:0]          dma_req,
    output logic                       irq
);
    ch_cfg_t [NUM_CH-1:0]             ctrl_q, ctrl_nxt;
    logic    [NUM_CH-1:0]             sw_q, udr_q, udr_set, udr_clr, hw_go, hold_we, ie;
    logic    [NUM_CH-1:0][CODE_W-1:0] hold_wv, code_w;
    logic                             ctrl_wr, sw_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign sw_wr   = bus_wr && (bus_addr == A_SWTRIG);

    // Control next value; selector frozen while the channel is enabled
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ctrl_nxt[c] = ch_cfg_t'(bus_wdata[c*8 +: 7]);
            if (ctrl_q[c].en) ctrl_nxt[c].tsel = ctrl_q[c].tsel;
        end
    end

    // Data write decode
    always_comb begin
        hold_we = '0;
        hold_wv = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_C0_R12: begin hold_we = 2'b01; hold_wv[0] = fmt_align(FMT_R12, bus_wdata[15:0]); end
                A_C0_L12: begin hold_we = 2'b01; hold_wv[0] = fmt_align(FMT_L12, bus_wdata[15:0]); end
                A_C0_R8:  begin hold_we = 2'b01; hold_wv[0] = fmt_align(FMT_R8,  bus_wdata[15:0]); end
                A_C1_R12: begin hold_we = 2'b10; hold_wv[1] = fmt_align(FMT_R12, bus_wdata[15:0]); end
                A_C1_L12: begin hold_we = 2'b10; hold_wv[1] = fmt_align(FMT_L12, bus_wdata[15:0]); end
                A_C1_R8:  begin hold_we = 2'b10; hold_wv[1] = fmt_align(FMT_R8,  bus_wdata[15:0]); end
                A_DU_R12: begin
                    hold_we    = 2'b11;
                    hold_wv[0] = fmt_align(FMT_R12, bus_wdata[15:0]);
                    hold_wv[1] = fmt_align(FMT_R12, bus_wdata[31:16]);
                end
                A_DU_L12: begin
                    hold_we    = 2'b11;
                    hold_wv[0] = fmt_align(FMT_L12, bus_wdata[15:0]);
                    hold_wv[1] = fmt_align(FMT_L12, bus_wdata[31:16]);
                end
                A_DU_R8: begin
                    hold_we    = 2'b11;
                    hold_wv[0] = fmt_align(FMT_R8, {8'h00, bus_wdata[7:0]});
                    hold_wv[1] = fmt_align(FMT_R8, {8'h00, bus_wdata[15:8]});
                end
                default: ;
            endcase
        end
    end

    assign udr_clr = (bus_wr && (bus_addr == A_STAT)) ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sw_q   <= '0;
            udr_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_nxt;
            sw_q  <= sw_wr ? bus_wdata[NUM_CH-1:0] : '0;
            udr_q <= udr_set | (udr_q & ~udr_clr);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dac_fe_chan #(.NUM_TMR(NUM_TMR)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_q[c].en),
            .trig_en (ctrl_q[c].trig_en),
            .tsel    (ctrl_q[c].tsel),
            .dma_en  (ctrl_q[c].dma_en),
            .ext_in  (ext_trig),
            .tmr_in  (tmr_trig),
            .sw_bit  (sw_q[c]),
            .hold_we (hold_we[c]),
            .hold_wv (hold_wv[c]),
            .dma_ack (dma_ack[c]),
            .code    (code_w[c]),
            .dma_req (dma_req[c]),
            .underrun(udr_set[c]),
            .hw_go   (hw_go[c])
        );
        assign ie[c] = ctrl_q[c].udr_ie;

        // R8: trigger on a pending request marks an underrun
        p_udr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req[c] && hw_go[c] |=> udr_q[c]);
        // R6: strobe bits live for a single cycle
        p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sw_q[c] && !sw_wr |=> !sw_q[c]);
    end

    assign dac_code = code_w;
    assign irq      = |(udr_q & ie);

    // R9: interrupt only with a recorded underrun
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (udr_q != '0));

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = {16'h0000, 1'b0, ctrl_q[1], 1'b0, ctrl_q[0]};
            A_SWTRIG: bus_rdata = {30'd0, sw_q};
            A_OUT:    bus_rdata = {4'h0, code_w[1], 4'h0, code_w[0]};
            A_STAT:   bus_rdata = {30'd0, udr_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/tb_dac_front_ctrl.sv
`timescale 1ns/1ps
module tb_dac_front_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic [3:0]  tmr_trig = 4'd0;
    logic [1:0]  dma_ack = 2'b00;
    logic [23:0] dac_code;
    logic [1:0]  dma_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_front_ctrl #(.NUM_TMR(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .tmr_trig(tmr_trig), .dma_ack(dma_ack), .dac_code(dac_code),
        .dma_req(dma_req), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [31:0] d;
        logic [11:0] e0;
        logic [11:0] e1;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{4'd2,  32'h0000_0ABC, 12'hABC, 12'h000},
        '{4'd5,  32'hFFFF_F321, 12'hABC, 12'h321},
        '{4'd3,  32'h0000_5670, 12'h567, 12'h321},
        '{4'd7,  32'h0000_01A5, 12'h567, 12'hA50},
        '{4'd4,  32'h0000_00FF, 12'hFF0, 12'hA50},
        '{4'd6,  32'h0000_FFF0, 12'hFF0, 12'hFFF},
        '{4'd8,  32'h0DEF_0123, 12'h123, 12'hDEF},
        '{4'd9,  32'hABC0_4560, 12'h456, 12'hABC},
        '{4'd10, 32'h0000_7F80, 12'h800, 12'h7F0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 codes", {8'h0, dac_code}, 32'h0);
        chk("R1 dma_req", {30'd0, dma_req}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        rd(4'd0, v);  chk("R1 ctrl", v, 32'h0);
        rd(4'd1, v);  chk("R1 strobe", v, 32'h0);
        rd(4'd12, v); chk("R1 status", v, 32'h0);
        rd(4'd11, v); chk("R1 readback", v, 32'h0);

        // R2 R3 R4 R11: formats with triggering off
        wr(4'd0, 32'h0000_0101);
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i].a, VEC[i].d);
            @(negedge clk);
            chk($sformatf("R2/R3/R4 vec%0d ch0", i), {20'd0, dac_code[11:0]}, {20'd0, VEC[i].e0});
            chk($sformatf("R2/R3/R4 vec%0d ch1", i), {20'd0, dac_code[23:12]}, {20'd0, VEC[i].e1});
            rd(4'd11, v);
            chk($sformatf("R11 vec%0d", i), v, {4'h0, VEC[i].e1, 4'h0, VEC[i].e0});
        end

        // R10: selector frozen while enabled
        wr(4'd0, 32'h0000_1E66);
        wr(4'd0, 32'h0000_1F67);
        rd(4'd0, v); chk("R10 enable write", v, 32'h0000_1F67);
        wr(4'd0, 32'h0000_1F63);
        rd(4'd0, v); chk("R10 selector kept", v, 32'h0000_1F67);

        // R5: triggered loads
        wr(4'd2, 32'h0000_0123);
        wr(4'd5, 32'h0000_0456);
        @(negedge clk);
        chk("R5 no load without trigger", {20'd0, dac_code[11:0]}, 32'h800);
        chk("R6 no load without strobe", {20'd0, dac_code[23:12]}, 32'h7F0);
        ext_trig = 1'b1;
        repeat (2) @(negedge clk);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 unselected source", {20'd0, dac_code[11:0]}, 32'h800);
        chk("R7 unselected no req", {30'd0, dma_req}, 32'h0);
        tmr_trig[0] = 1'b1;
        @(negedge clk);
        chk("R5 latency first edge", {20'd0, dac_code[11:0]}, 32'h800);
        @(negedge clk);
        chk("R5 loaded", {20'd0, dac_code[11:0]}, 32'h123);
        chk("R7 req raised", {30'd0, dma_req}, 32'h1);
        wr(4'd2, 32'h0000_0321);
        repeat (3) @(negedge clk);
        chk("R5 level no retrigger", {20'd0, dac_code[11:0]}, 32'h123);
        chk("R7 req held", {30'd0, dma_req}, 32'h1);
        tmr_trig[0] = 1'b0;
        @(negedge clk);
        tmr_trig[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 second edge", {20'd0, dac_code[11:0]}, 32'h321);
        rd(4'd12, v); chk("R8 underrun flag", v, 32'h1);
        chk("R9 irq set", {31'd0, irq}, 32'h1);
        tmr_trig[0] = 1'b0;
        dma_ack[0] = 1'b1;
        @(negedge clk);
        dma_ack[0] = 1'b0;
        chk("R7 req cleared by ack", {30'd0, dma_req}, 32'h0);
        wr(4'd12, 32'h0000_0001);
        rd(4'd12, v); chk("R9 W1C", v, 32'h0);
        chk("R9 irq cleared", {31'd0, irq}, 32'h0);

        // R6: software strobe
        wr(4'd1, 32'h0000_0003);
        chk("R6 before load", {20'd0, dac_code[23:12]}, 32'h7F0);
        @(negedge clk);
        chk("R6 loaded", {20'd0, dac_code[23:12]}, 32'h456);
        chk("R6 timer channel ignores strobe", {20'd0, dac_code[11:0]}, 32'h321);
        rd(4'd1, v); chk("R6 self clear", v, 32'h0);
        chk("R7 no req on strobe", {30'd0, dma_req}, 32'h0);

        wr(4'd0, 32'h0000_1E1E);
        wr(4'd0, 32'h0000_1F1F);
        wr(4'd8, 32'h0AAA_0555);
        @(negedge clk);
        chk("R6 dual waits", {8'h0, dac_code}, {8'h0, 12'h456, 12'h321});
        wr(4'd1, 32'h0000_0003);
        @(negedge clk);
        chk("R6 dual strobe", {8'h0, dac_code}, {8'h0, 12'hAAA, 12'h555});

        // R12: disabled channel holds
        wr(4'd0, 32'h0000_0000);
        wr(4'd2, 32'h0000_0777);
        repeat (2) @(negedge clk);
        chk("R12 disabled hold", {20'd0, dac_code[11:0]}, 32'h555);

        done = 1'b1;
        finish_run();
    end
endmodule